// File: doc/BRIEF.md
# I2C Clock Phase Generator

This block produces the SCL waveform for an I2C master from a fast reference clock. A power-of-two divider turns the reference clock into a count enable. Two 5-bit width settings give the number of count cycles in the low phase and in the high phase. Each phase is the width setting plus a fixed overhead. The overhead is 4 count cycles when the divider is bypassed and 3 when it divides. The divider select sits in a configuration byte. That byte can change the select only when its lock-release bit is set in the same write.

The high phase does not start when the block releases SCL. It starts once the resynchronised SCL level reads high. Slow rising edges and a target that holds SCL low therefore lengthen the period without corrupting it. Two one-cycle strobes drive the byte engine. One marks the middle of the high phase, where SDA is sampled. The other marks the last cycle of the low phase, where SDA may change.

The state machine has four states. IDLE releases SCL. LOW drives SCL low. WAIT_HI releases SCL and waits for the synchronised level. HIGH counts the high phase. The transitions are:
- IDLE→LOW when enabled.
- LOW→WAIT_HI when the low count expires.
- WAIT_HI→HIGH when the synchronised SCL is high.
- HIGH→LOW when the high count expires.
- Any state→IDLE when the enable is low.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset, scl_drive_low, tick_sample and tick_change are 0 and div_sel is 0.
- R2: A cycle with cfg_wr=1 and cfg_wdata[3]=1 loads cfg_wdata[6:4] into div_sel, visible from the next cycle. The count enable then fires once every 2^div_sel reference cycles.
- R3: A cycle with cfg_wr=1 and cfg_wdata[3]=0 leaves div_sel and the SCL timing unchanged.
- R4: While enabled, scl_drive_low stays high for exactly (L+K)·2^div_sel reference cycles per period. L is low_width and K is 4 when div_sel=0, otherwise 3.
- R5: The high phase begins only after scl_in has passed the 2-stage synchroniser. With scl_in following the released line, SCL stays released for 3 + (H+K)·2^div_sel reference cycles, where H is high_width.
- R6: If scl_in is held low for S reference cycles after release, the released time grows by exactly S cycles.
- R7: A width setting of 0 gives the same timing as a setting of 1.
- R8: tick_change is high for one cycle, in the last cycle of the low phase, and SCL is released on the next cycle.
- R9: tick_sample is high for one cycle in the high phase. It fires on count enable number m+1 of that phase, with m = (H+K-1)>>1. Its offset from release is 3+S+(m+1)·2^div_sel-1 cycles.
- R10: When enable is low, SCL is released from the next cycle and no strobe fires. The low value takes priority over a phase end in the same cycle. Raising enable restarts the waveform with a full low phase, driven low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the generator; low releases SCL |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration byte: [6:4] divider select, [3] lock release |
| high_width | input | 5 | High-phase width setting |
| low_width | input | 5 | Low-phase width setting |
| scl_in | input | 1 | Noise-filtered SCL line level |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| tick_sample | output | 1 | SDA sample strobe, middle of high phase |
| tick_change | output | 1 | SDA change strobe, end of low phase |
| div_sel | output | 3 | Current divider select |

## Verification
A low phase can expire in the same cycle that enable drops, so the phase-end transition and the disable compete. The bench waits for the cycle in which tick_change is high and lowers enable in that same cycle. It then expects SCL to stay released with no strobe, rather than moving to WAIT_HI. After enable returns, it expects a full-length low phase. Stretching is provoked by holding scl_in low for a set number of cycles after release, and the added released time is judged cycle by cycle.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOW     = 2'd1,
        ST_WAIT_HI = 2'd2,
        ST_HIGH    = 2'd3
    } scl_state_t;

    localparam int OVH_BYPASS = 4;
    localparam int OVH_DIVIDE = 3;
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int SEL_W    = 3,
    parameter int SEL_LSB  = 4,
    parameter int LOCK_BIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_wdata,
    input  logic             clr,
    output logic [SEL_W-1:0] div_sel,
    output logic             cen
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [SEL_W-1:0] sel_q;
    logic [DIV_W-1:0] pre_cnt;
    logic [DIV_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (cfg_wr && cfg_wdata[LOCK_BIT])
            sel_q <= cfg_wdata[SEL_LSB +: SEL_W];
    end

    always_comb begin
        mask = ~({DIV_W{1'b1}} << sel_q);
        cen  = !clr && ((pre_cnt & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            pre_cnt <= '0;
        else
            pre_cnt <= pre_cnt + 1'b1;
    end

    assign div_sel = sel_q;

    // R3
    wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && !cfg_wdata[LOCK_BIT] |=> $stable(div_sel));

    // R2
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && cfg_wdata[LOCK_BIT] |=> div_sel == $past(cfg_wdata[SEL_LSB +: SEL_W]));
endmodule

// File: rtl/scl_sync.sv
module scl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) q[0] <= 1'b0;
                    else        q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) q[i] <= 1'b0;
                    else        q[i] <= q[i-1];
                end
            end
        end
    endgenerate

    assign dout = q[STAGES-1];
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cen,
    input  logic             scl_hi,
    input  logic             bypass,
    input  logic [CNT_W-1:0] high_width,
    input  logic [CNT_W-1:0] low_width,
    output logic             drive_low,
    output logic             tick_change,
    output logic             tick_sample,
    output logic             pre_clr
);
    localparam int PH_W = CNT_W + 1;

    scl_state_t      state;
    logic [PH_W-1:0] cnt;
    logic [PH_W-1:0] n_lo;
    logic [PH_W-1:0] n_hi;
    logic [PH_W-1:0] mid;
    logic            lo_done;
    logic            hi_done;

    function automatic logic [PH_W-1:0] phase_len(input logic [CNT_W-1:0] w, input logic byp);
        logic [PH_W-1:0] base;
        base = (w == '0) ? PH_W'(1) : PH_W'(w);
        return base + (byp ? PH_W'(OVH_BYPASS) : PH_W'(OVH_DIVIDE));
    endfunction

    always_comb begin
        n_lo    = phase_len(low_width, bypass);
        n_hi    = phase_len(high_width, bypass);
        mid     = (n_hi - 1'b1) >> 1;
        lo_done = cen && (cnt == n_lo - 1'b1);
        hi_done = cen && (cnt == n_hi - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state <= ST_LOW;
                    cnt   <= '0;
                end
                ST_LOW: begin
                    if (lo_done) begin
                        state <= ST_WAIT_HI;
                        cnt   <= '0;
                    end else if (cen) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WAIT_HI: begin
                    if (scl_hi) begin
                        state <= ST_HIGH;
                        cnt   <= '0;
                    end
                end
                ST_HIGH: begin
                    if (hi_done) begin
                        state <= ST_LOW;
                        cnt   <= '0;
                    end else if (cen) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    always_comb begin
        drive_low   = 1'b0;
        tick_change = 1'b0;
        tick_sample = 1'b0;
        pre_clr     = 1'b1;
        unique case (state)
            ST_IDLE:    pre_clr = 1'b1;
            ST_LOW: begin
                drive_low   = 1'b1;
                pre_clr     = 1'b0;
                tick_change = enable && lo_done;
            end
            ST_WAIT_HI: pre_clr = 1'b1;
            ST_HIGH: begin
                pre_clr     = 1'b0;
                tick_sample = enable && cen && (cnt == mid);
            end
            default:    pre_clr = 1'b1;
        endcase
    end

    // R8
    chg_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_change |=> !drive_low);

    // R5
    hi_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_HI) && !scl_hi |=> state != ST_HIGH);

    // R10
    dis_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !drive_low && !tick_change && !tick_sample);

    // R9
    tick_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_sample && tick_change));
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
    import scl_gen_pkg::*;
#(
    parameter int CNT_W       = 5,
    parameter int SEL_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_wdata,
    input  logic [CNT_W-1:0] high_width,
    input  logic [CNT_W-1:0] low_width,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             tick_sample,
    output logic             tick_change,
    output logic [SEL_W-1:0] div_sel
);
    logic cen;
    logic pre_clr;
    logic scl_hi;
    logic bypass;

    scl_prescaler #(.SEL_W(SEL_W), .SEL_LSB(4), .LOCK_BIT(3)) i_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .clr       (pre_clr),
        .div_sel   (div_sel),
        .cen       (cen)
    );

    scl_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (scl_in),
        .dout  (scl_hi)
    );

    assign bypass = (div_sel == '0);

    scl_phase_fsm #(.CNT_W(CNT_W)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .cen         (cen),
        .scl_hi      (scl_hi),
        .bypass      (bypass),
        .high_width  (high_width),
        .low_width   (low_width),
        .drive_low   (scl_drive_low),
        .tick_change (tick_change),
        .tick_sample (tick_sample),
        .pre_clr     (pre_clr)
    );

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !scl_drive_low && !tick_change && !tick_sample && div_sel == '0);
endmodule

// File: tb/test_scl_rate_gen.sv
module test_scl_rate_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [4:0] high_width = 5'd1;
    logic [4:0] low_width = 5'd1;
    logic       scl_in;
    logic       scl_drive_low, tick_sample, tick_change;
    logic [2:0] div_sel;

    int checks = 0;
    int errors = 0;
    int stretch = 0;
    logic [15:0] rel_cnt;

    // {div select, high width, low width, stretch}
    localparam logic [16:0] VEC [6] = '{
        {3'd0, 5'd5,  5'd7,  4'd0},
        {3'd1, 5'd3,  5'd2,  4'd0},
        {3'd2, 5'd0,  5'd0,  4'd0},
        {3'd0, 5'd31, 5'd31, 4'd5},
        {3'd7, 5'd1,  5'd1,  4'd0},
        {3'd3, 5'd10, 5'd4,  4'd9}
    };

    always #5 clk = ~clk;

    scl_rate_gen i_scl_rate_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .high_width(high_width), .low_width(low_width),
        .scl_in(scl_in), .scl_drive_low(scl_drive_low), .tick_sample(tick_sample),
        .tick_change(tick_change), .div_sel(div_sel)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || scl_drive_low) rel_cnt <= '0;
        else if (rel_cnt != 16'hFFFF) rel_cnt <= rel_cnt + 1'b1;
    end
    assign scl_in = !scl_drive_low && (int'(rel_cnt) >= stretch);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ph_n(input int w, input int c);
        return ((w == 0) ? 1 : w) + ((c == 0) ? 4 : 3);
    endfunction

    task automatic cfg_write(input int sel, input bit unlock);
        cfg_wdata = {1'b0, 3'(sel), unlock, 3'b000};
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        @(negedge clk);
    endtask

    int lo_len, rel_len, chg_at, smp_at;

    task automatic measure();
        while (scl_drive_low) @(negedge clk);
        while (!scl_drive_low) @(negedge clk);
        lo_len = 0; chg_at = -1;
        while (scl_drive_low) begin
            if (tick_change) chg_at = lo_len;
            lo_len++;
            @(negedge clk);
        end
        rel_len = 0; smp_at = -1;
        while (!scl_drive_low) begin
            if (tick_sample) smp_at = rel_len;
            rel_len++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung run, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!scl_drive_low && !tick_change && !tick_sample, "R1", int'(scl_drive_low), 0);
        check(div_sel == 3'd0, "R1", int'(div_sel), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!scl_drive_low, "R1", int'(scl_drive_low), 0);

        // R2 load with lock release; R3 protected write ignored
        cfg_write(5, 1'b1);
        check(div_sel == 3'd5, "R2", int'(div_sel), 5);
        cfg_write(2, 1'b0);
        check(div_sel == 3'd5, "R3", int'(div_sel), 5);

        // R3 timing unchanged after protected write: div 5, widths 1
        high_width = 5'd1; low_width = 5'd1; stretch = 0;
        enable = 1'b1;
        measure();
        check(lo_len == (4 << 5), "R3", lo_len, 4 << 5);
        enable = 1'b0;
        repeat (3) @(negedge clk);

        // vector table: R2 R4 R5 R6 R7 R8 R9
        for (int v = 0; v < 6; v++) begin
            int c, hw, lw, s, nh, m;
            c  = int'(VEC[v][16:14]);
            hw = int'(VEC[v][13:9]);
            lw = int'(VEC[v][8:4]);
            s  = int'(VEC[v][3:0]);
            enable = 1'b0;
            @(negedge clk);
            cfg_write(c, 1'b1);
            high_width = 5'(hw); low_width = 5'(lw); stretch = s;
            enable = 1'b1;
            measure();
            nh = ph_n(hw, c);
            m  = (nh - 1) >> 1;
            check(lo_len == (ph_n(lw, c) << c), (lw == 0) ? "R7" : "R4", lo_len, ph_n(lw, c) << c);
            check(rel_len == 3 + s + (nh << c), (s != 0) ? "R6" : "R5", rel_len, 3 + s + (nh << c));
            check(chg_at == lo_len - 1, "R8", chg_at, lo_len - 1);
            check(smp_at == 3 + s + ((m + 1) << c) - 1, "R9", smp_at, 3 + s + ((m + 1) << c) - 1);
        end

        // R10 disable coinciding with end of low phase
        enable = 1'b0;
        stretch = 0;
        @(negedge clk);
        cfg_write(0, 1'b1);
        high_width = 5'd5; low_width = 5'd7;
        enable = 1'b1;
        while (!tick_change) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(!scl_drive_low, "R10", int'(scl_drive_low), 0);
        begin
            int busy = 0;
            for (int k = 0; k < 10; k++) begin
                if (scl_drive_low || tick_change || tick_sample) busy++;
                @(negedge clk);
            end
            check(busy == 0, "R10", busy, 0);
        end
        enable = 1'b1;
        @(negedge clk);
        check(scl_drive_low, "R10", int'(scl_drive_low), 1);
        lo_len = 0;
        while (scl_drive_low) begin
            lo_len++;
            @(negedge clk);
        end
        check(lo_len == 11, "R10", lo_len, 11);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule